// File: doc/BRIEF.md
# Disk Sector Scan Comparator

This block performs the comparison step of a disk scan operation. A transfer sequencer streams the bytes of each sector out of the sector buffer. For each disk byte, the block fetches the matching byte of a search argument held in memory, and it classifies every whole sector against that argument. A sector is classed as equal, low or high. An exact match raises a sticky found indication that the host can test. When a sector's class equals the condition code the host asked for, the block stops the scan.

The argument window starts at an address given with the start command. The window moves forward by one sector length for every sector compared. The sequencer still owns sector numbering and end-of-cylinder handling. It ends a scan with a halt input, or it reports a cylinder mismatch on a sector's first byte. A cylinder mismatch aborts the scan with a read error code.

Top module: `scan_compare`

## Requirements
- R1: After reset, busy, found, stop and res_valid are 0, and scan_err is 16'h0000.
- R2: A start pulse sets busy, latches cond_code and points arg_addr at arg_base. It also clears found and scan_err. start takes priority over every other input in the same cycle.
- R3: A sector's result is 2'd0 when every compared byte equals the argument. It is 2'd1 when the deciding disk byte is below the argument byte, and 2'd3 when the deciding disk byte is above it. The value 2'd2 is never produced.
- R4: The deciding byte is the first unequal byte in byte order. Bytes after it do not change the result.
- R5: Byte index 255 of each sector is left out of the comparison. A difference at that index alone still gives result 2'd0.
- R6: A sector with result 2'd0 sets found. found then stays 1 until the next start.
- R7: result and a one-cycle res_valid pulse appear at the clock edge that accepts the sector's last byte. If the result equals the latched code, stop pulses in the same cycle and busy drops. Bytes offered after that change neither result, res_valid nor found. A latched code of 2'd2 never stops the scan.
- R8: While busy, arg_addr equals arg_base + 256*k + i for byte i of the k-th sector since start. The memory returns arg_data for arg_addr within the same cycle.
- R9: If cyl_mismatch is high when a sector's first byte is offered, the scan aborts. busy drops, scan_err becomes 16'h0800 (bit 11), no result is given and found keeps its value.
- R10: halt while busy ends the scan without producing a result and without changing found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a new scan |
| halt | input | 1 | End the scan from the sequencer |
| cond_code | input | 2 | Requested stop condition, latched at start |
| arg_base | input | AW | First address of the argument |
| byte_valid | input | 1 | A disk byte is offered this cycle |
| disk_byte | input | 8 | Byte from the sector buffer |
| cyl_mismatch | input | 1 | Cylinder check failed for the sector now starting |
| arg_addr | output | AW | Argument read address |
| arg_data | input | 8 | Argument byte at arg_addr |
| busy | output | 1 | Scan in progress |
| result | output | 2 | Class of the last completed sector |
| res_valid | output | 1 | One-cycle pulse when result is updated |
| stop | output | 1 | One-cycle pulse: result matched the requested code |
| found | output | 1 | Sticky equal-sector flag |
| scan_err | output | 16 | Error status, 16'h0800 on cylinder abort |

## Verification
The embedded properties check on every cycle that stop coincides with a result equal to the latched code and with busy low. They also check that found is not lost between starts, that the code 2'd2 never appears as a result, that an error state never coexists with an active scan, and that the argument address moves on by exactly one step across a sector boundary. Only the directed scenarios can show that the class of a sector is correct: the first-difference rule, the exclusion of byte 255, that the scan continues for a code of 2'd2, and that bytes after a stop are ignored. Those depend on the data streamed in, so the bench builds them from its own argument memory.

// File: rtl/scan_compare.sv
module scan_compare #(
  parameter int AW         = 16,
  parameter int SECT_BYTES = 256,
  parameter int SKIP_IDX   = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          halt,
  input  logic [1:0]    cond_code,
  input  logic [AW-1:0] arg_base,
  input  logic          byte_valid,
  input  logic [7:0]    disk_byte,
  input  logic          cyl_mismatch,
  output logic [AW-1:0] arg_addr,
  input  logic [7:0]    arg_data,
  output logic          busy,
  output logic [1:0]    result,
  output logic          res_valid,
  output logic          stop,
  output logic          found,
  output logic [15:0]   scan_err
);
  localparam int IW = $clog2(SECT_BYTES);
  localparam logic [IW-1:0] LAST = IW'(SECT_BYTES - 1);
  localparam logic [IW-1:0] SKIP = IW'(SKIP_IDX);
  localparam logic [AW-1:0] STEP = AW'(SECT_BYTES);
  localparam logic [15:0] ERR_CYL = 16'h0800;

  logic [AW-1:0] sect_base;
  logic [IW-1:0] idx;
  logic [1:0]    acc, cc_q, byte_cls, fin;
  logic          take, abort_cyl;

  assign arg_addr  = sect_base + AW'(idx);
  assign byte_cls  = (idx == SKIP)           ? 2'd0 :
                     (disk_byte < arg_data)  ? 2'd1 :
                     (disk_byte > arg_data)  ? 2'd3 : 2'd0;
  assign fin       = (acc != 2'd0) ? acc : byte_cls;
  assign take      = busy && byte_valid && !start && !halt;
  assign abort_cyl = take && (idx == '0) && cyl_mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sect_base <= '0; idx <= '0; acc <= 2'd0; cc_q <= 2'd0;
      result <= 2'd0; res_valid <= 1'b0; stop <= 1'b0; found <= 1'b0;
      scan_err <= 16'h0000;
    end else begin
      res_valid <= 1'b0;
      stop      <= 1'b0;
      if (start) begin
        busy <= 1'b1; sect_base <= arg_base; idx <= '0; acc <= 2'd0;
        cc_q <= cond_code; found <= 1'b0; scan_err <= 16'h0000;
      end else if (busy && halt) begin
        busy <= 1'b0;
      end else if (abort_cyl) begin
        busy <= 1'b0;
        scan_err <= ERR_CYL;
      end else if (take) begin
        if (idx == LAST) begin
          result    <= fin;
          res_valid <= 1'b1;
          acc       <= 2'd0;
          idx       <= '0;
          sect_base <= sect_base + STEP;
          if (fin == 2'd0) found <= 1'b1;
          if (fin == cc_q) begin
            stop <= 1'b1;
            busy <= 1'b0;
          end
        end else begin
          idx <= idx + 1'b1;
          acc <= fin;
        end
      end
    end
  end

  p_stop_on_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> (res_valid && result == cc_q && !busy));

  p_found_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !start) |=> found);

  p_no_code_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (result != 2'd2));

  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_err != 16'h0000) |-> (!busy && !res_valid));

  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !abort_cyl && idx == LAST) |=> (arg_addr == $past(arg_addr) + 1'b1));

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halt && !start) |=> (!busy && !res_valid));
endmodule

// File: tb/test_scan_compare.sv
module test_scan_compare;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, halt = 1'b0, byte_valid = 1'b0, cyl_mismatch = 1'b0;
  logic [1:0] cond_code = 2'd0;
  logic [15:0] arg_base = 16'h0000;
  logic [7:0] disk_byte = 8'h00;
  logic [15:0] arg_addr;
  logic [7:0] arg_data;
  logic busy, res_valid, stop, found;
  logic [1:0] result;
  logic [15:0] scan_err;
  logic [7:0] amem [0:4095];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign arg_data = amem[arg_addr[11:0]];

  scan_compare i_scan_compare (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .cond_code(cond_code),
    .arg_base(arg_base), .byte_valid(byte_valid), .disk_byte(disk_byte),
    .cyl_mismatch(cyl_mismatch), .arg_addr(arg_addr), .arg_data(arg_data),
    .busy(busy), .result(result), .res_valid(res_valid), .stop(stop),
    .found(found), .scan_err(scan_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] cc, input logic [15:0] base);
    @(negedge clk);
    start = 1'b1; cond_code = cc; arg_base = base;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(arg_addr == base, "R2", "arg_addr after start", arg_addr, base);
    chk(found == 1'b0, "R2", "found cleared", found, 0);
    chk(scan_err == 16'h0, "R2", "scan_err cleared", scan_err, 0);
  endtask

  task automatic send_sector(input logic [15:0] sbase, input bit addr_chk,
                             input int i1, input int d1, input int i2, input int d2);
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      disk_byte = 8'(int'(amem[(sbase + 16'(i)) & 16'h0FFF]) +
                     ((i == i1) ? d1 : 0) + ((i == i2) ? d2 : 0));
      #0.1;
      if (addr_chk && arg_addr != sbase + 16'(i)) bad++;
    end
    @(negedge clk);
    byte_valid = 1'b0;
    if (addr_chk) chk(bad == 0, "R8", "argument address mismatches", bad, 0);
  endtask

  task automatic expect_res(input string req, input logic [1:0] r, input bit st,
                            input bit f, input bit b);
    chk(res_valid == 1'b1, req, "res_valid", res_valid, 1);
    chk(result == r, req, "result", result, r);
    chk(stop == st, "R7", "stop", stop, st);
    chk(found == f, "R6", "found", found, f);
    chk(busy == b, "R7", "busy", busy, b);
  endtask

  task automatic t_reset;
    chk(busy == 0 && stop == 0 && res_valid == 0, "R1", "busy/stop/res_valid", busy, 0);
    chk(found == 0, "R1", "found", found, 0);
    chk(scan_err == 16'h0, "R1", "scan_err", scan_err, 0);
  endtask

  task automatic t_classes;
    do_start(2'd1, 16'h0100);
    send_sector(16'h0100, 1, -1, 0, -1, 0);
    expect_res("R3", 2'd0, 0, 1, 1);
    send_sector(16'h0200, 1, 10, 10, -1, 0);
    expect_res("R3", 2'd3, 0, 1, 1);
    send_sector(16'h0300, 1, 0, -10, 5, 10);
    expect_res("R4", 2'd1, 1, 1, 0);
    @(negedge clk);
    chk(res_valid == 0 && stop == 0, "R7", "pulses last one cycle", res_valid, 0);
    send_sector(16'h0400, 0, 3, 10, -1, 0);
    chk(res_valid == 0, "R7", "bytes after stop give no result", res_valid, 0);
    chk(result == 2'd1, "R7", "result kept after stop", result, 1);
    chk(found == 1, "R7", "found kept after stop", found, 1);
  endtask

  task automatic t_skip;
    do_start(2'd3, 16'h0800);
    send_sector(16'h0800, 1, 255, 10, -1, 0);
    expect_res("R5", 2'd0, 0, 1, 1);
    send_sector(16'h0900, 1, 254, 10, 255, -10);
    expect_res("R5", 2'd3, 1, 1, 0);
  endtask

  task automatic t_code_two;
    do_start(2'd2, 16'h0A00);
    send_sector(16'h0A00, 1, 7, -10, -1, 0);
    expect_res("R7", 2'd1, 0, 0, 1);
    send_sector(16'h0B00, 1, 9, 10, -1, 0);
    expect_res("R7", 2'd3, 0, 0, 1);
    send_sector(16'h0C00, 1, -1, 0, -1, 0);
    expect_res("R6", 2'd0, 0, 1, 1);
    @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    chk(busy == 0, "R10", "busy after halt", busy, 0);
    chk(res_valid == 0, "R10", "no result on halt", res_valid, 0);
    chk(found == 1, "R10", "found kept on halt", found, 1);
  endtask

  task automatic t_cylinder;
    do_start(2'd1, 16'h0000);
    send_sector(16'h0000, 1, -1, 0, -1, 0);
    expect_res("R6", 2'd0, 0, 1, 1);
    @(negedge clk);
    byte_valid = 1'b1; cyl_mismatch = 1'b1; disk_byte = 8'h00;
    @(negedge clk);
    byte_valid = 1'b0; cyl_mismatch = 1'b0;
    chk(scan_err == 16'h0800, "R9", "scan_err on cylinder abort", scan_err, 16'h0800);
    chk(busy == 0, "R9", "busy on cylinder abort", busy, 0);
    chk(res_valid == 0, "R9", "no result on abort", res_valid, 0);
    chk(found == 1, "R9", "found unchanged on abort", found, 1);
    do_start(2'd0, 16'h0000);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) amem[a] = 8'((a * 5) % 200 + 20);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_classes();
    t_skip();
    t_code_two();
    t_cylinder();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule